// File: doc/BRIEF.md
# DSP Fixed-Point ALU Unit

This block is the fixed-point arithmetic stage of a DSP datapath. It owns a small file of eight registers (four 32-bit data registers, two 32-bit multiplier-side registers and two 40-bit accumulators). In each instruction slot it picks two source operands and a destination, and it runs one of nine operations: add, subtract, add with carry, subtract with borrow, compare, copy, absolute value, negate or clear. Carry, zero and negative flags come out of every slot so that results can be chained across words and compared.

A load-write port stands in for the memory side. It can write any register in the same slot as an ALU operation. Within a slot the ALU always reads the register contents from before the slot. A load into one of its sources is not forwarded, and a load to the same register as the ALU result overwrites that result. A combinational read port shows any register, so the state can be observed.

Top module: `dsp_alu_unit`

## Requirements
- R1: After reset, all eight registers read zero, and flag_c, flag_z and flag_n are 0.
- R2: Register codes are 0=X0, 1=X1, 2=Y0, 3=Y1, 4=M0, 5=M1, 6=A0, 7=A1. sx_sel 0..3 selects X0, X1, A0, A1. sy_sel 0..3 selects Y0, Y1, M0, M1. dz_sel takes any register code. du_sel 0..3 selects X0, Y0, A0, A1.
- R3: op 0 (add) and op 1 (subtract) form the 40-bit Sx+Sy or Sx-Sy. The result is written to Du when use_du=1 and to Dz otherwise. flag_c takes the carry out of bit 39 for add and the borrow for subtract.
- R4: op 2 (add with carry) forms Sx+Sy+C. op 3 (subtract with borrow) forms Sx-Sy-C. Both set C from the new carry or borrow and write only Dz, whatever use_du says.
- R5: op 4 (compare) forms Sx-Sy, sets C to the borrow and Z/N from the difference, and writes no register.
- R6: op 5/6 copies Sx/Sy. op 7/8 writes |Sx|/|Sy|. op 9/10 writes 0-Sx/0-Sy. Absolute value and negate set C to the borrow of the subtraction from zero. Copy leaves C unchanged.
- R7: op 11 (clear) writes zero to Dz, sets Z=1 and N=0, and leaves C unchanged.
- R8: For every operation except clear, Z is set when the 40-bit result is zero and N equals bit 39 of the result.
- R9: A 32-bit register keeps the low 32 bits of a result and reads back sign-extended to 40 bits. Accumulators keep all 40 bits.
- R10: An ALU operation sees the register values from before its slot, even when a same-slot load targets one of its sources.
- R11: A load writes its 32-bit value sign-extended. When the load and the ALU target the same register in one slot, the load value is kept.
- R12: With issue low, or with op codes 12 to 15, no register and no flag changes. A load in the same slot still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | ALU operation valid this slot |
| op | input | 4 | Operation code |
| sx_sel | input | 2 | Source 1 select |
| sy_sel | input | 2 | Source 2 select |
| dz_sel | input | 3 | Main destination register code |
| use_du | input | 1 | Route add/subtract result to the alternate destination |
| du_sel | input | 2 | Alternate destination select |
| ld_en | input | 1 | Load write this slot |
| ld_sel | input | 3 | Load target register code |
| ld_data | input | 32 | Load value |
| rd_sel | input | 3 | Observation read register code |
| rd_data | output | 40 | Selected register, sign-extended |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
A carry or borrow out of bit 39 is the hardest case to reach. Loads fill registers with only 32 sign-extended bits, so an accumulator has to be built up to the edge of its range first. Directed slots negate a small value into an accumulator to get all ones, then add one and continue with add-with-carry, which reaches the 40-bit carry and the chained flag use. Random slots with a fixed seed mix loads into ALU sources and destinations in the same slot, which covers both the no-forwarding order and the case where the load overwrites the ALU result.

// File: rtl/dsp_alu_unit.sv
module dsp_alu_unit #(
  parameter int DW = 32,
  parameter int GW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [3:0]       op,
  input  logic [1:0]       sx_sel,
  input  logic [1:0]       sy_sel,
  input  logic [2:0]       dz_sel,
  input  logic             use_du,
  input  logic [1:0]       du_sel,
  input  logic             ld_en,
  input  logic [2:0]       ld_sel,
  input  logic [DW-1:0]    ld_data,
  input  logic [2:0]       rd_sel,
  output logic [DW+GW-1:0] rd_data,
  output logic             flag_c,
  output logic             flag_z,
  output logic             flag_n
);
  localparam int AW = DW + GW;

  localparam logic [3:0] OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDC = 4'd2,  OP_SUBC = 4'd3;
  localparam logic [3:0] OP_CMP  = 4'd4,  OP_CPYX = 4'd5,  OP_CPYY = 4'd6,  OP_ABSX = 4'd7;
  localparam logic [3:0] OP_ABSY = 4'd8,  OP_NEGX = 4'd9,  OP_NEGY = 4'd10, OP_CLR  = 4'd11;

  logic [7:0][AW-1:0] rf;

  logic [2:0]    sx_idx, sy_idx, du_idx, wr_idx;
  logic [AW-1:0] opx, opy, src, res;
  logic [AW:0]   ext;
  logic          wr_en, upd_c, upd_zn, is_clr;

  assign sx_idx = {sx_sel[1], sx_sel[1], sx_sel[0]};
  assign sy_idx = 3'd2 + {1'b0, sy_sel};
  assign opx    = rf[sx_idx];
  assign opy    = rf[sy_idx];
  assign src    = (op == OP_ABSY || op == OP_NEGY || op == OP_CPYY) ? opy : opx;
  assign rd_data = rf[rd_sel];

  always_comb begin
    case (du_sel)
      2'd0:    du_idx = 3'd0;
      2'd1:    du_idx = 3'd2;
      2'd2:    du_idx = 3'd6;
      default: du_idx = 3'd7;
    endcase
  end

  always_comb begin
    ext    = '0;
    upd_c  = 1'b0;
    upd_zn = 1'b1;
    wr_en  = issue;
    is_clr = 1'b0;
    case (op)
      OP_ADD:  begin ext = {1'b0, opx} + {1'b0, opy}; upd_c = 1'b1; end
      OP_SUB:  begin ext = {1'b0, opx} - {1'b0, opy}; upd_c = 1'b1; end
      OP_ADDC: begin ext = {1'b0, opx} + {1'b0, opy} + {{AW{1'b0}}, flag_c}; upd_c = 1'b1; end
      OP_SUBC: begin ext = {1'b0, opx} - {1'b0, opy} - {{AW{1'b0}}, flag_c}; upd_c = 1'b1; end
      OP_CMP:  begin ext = {1'b0, opx} - {1'b0, opy}; upd_c = 1'b1; wr_en = 1'b0; end
      OP_CPYX, OP_CPYY: ext = {1'b0, src};
      OP_ABSX, OP_ABSY: begin
        ext   = src[AW-1] ? ({(AW+1){1'b0}} - {1'b0, src}) : {1'b0, src};
        upd_c = 1'b1;
      end
      OP_NEGX, OP_NEGY: begin ext = {(AW+1){1'b0}} - {1'b0, src}; upd_c = 1'b1; end
      OP_CLR:  begin ext = '0; is_clr = 1'b1; upd_zn = 1'b0; end
      default: begin wr_en = 1'b0; upd_zn = 1'b0; end
    endcase
  end

  assign res    = ext[AW-1:0];
  assign wr_idx = ((op == OP_ADD || op == OP_SUB) && use_du) ? du_idx : dz_sel;

  function automatic logic [AW-1:0] fit(input logic [2:0] idx, input logic [AW-1:0] v);
    fit = (idx[2:1] == 2'b11) ? v : {{GW{v[DW-1]}}, v[DW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf     <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      if (wr_en) rf[wr_idx] <= fit(wr_idx, res);
      if (ld_en) rf[ld_sel] <= {{GW{ld_data[DW-1]}}, ld_data};
      if (issue && upd_c) flag_c <= ext[AW];
      if (issue && upd_zn) begin
        flag_z <= (res == '0);
        flag_n <= res[AW-1];
      end
      if (issue && is_clr) begin
        flag_z <= 1'b1;
        flag_n <= 1'b0;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (rf == '0) && !flag_c && !flag_z && !flag_n);

  assert_clr_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == OP_CLR |=> flag_z && !flag_n && $stable(flag_c));

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == OP_CMP && !ld_en |=> $stable(rf));

  assert_copy_keeps_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == OP_CPYX || op == OP_CPYY) |=> $stable(flag_c));

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> rf[$past(ld_sel)] == {{GW{$past(ld_data[DW-1])}}, $past(ld_data)});

  assert_idle_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue || op > OP_CLR) && !ld_en |=> $stable(rf) && $stable(flag_c) && $stable(flag_z) && $stable(flag_n));

  assert_narrow_signext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0][AW-1:DW-1] == '0 || rf[0][AW-1:DW-1] == '1);
endmodule

// File: tb/dsp_alu_unit_tb.sv
`timescale 1ns/1ps
module dsp_alu_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  sx_sel = '0, sy_sel = '0, du_sel = '0;
  logic [2:0]  dz_sel = '0, ld_sel = '0, rd_sel = '0;
  logic        use_du = 1'b0, ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic [39:0] rd_data;
  logic        flag_c, flag_z, flag_n;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  logic [39:0] m [8];
  logic mc, mz, mn;

  always #2.5 clk = ~clk;

  dsp_alu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .sx_sel(sx_sel), .sy_sel(sy_sel),
    .dz_sel(dz_sel), .use_du(use_du), .du_sel(du_sel), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n));

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: tag_of = "R3";
      4'd2, 4'd3: tag_of = "R4";
      4'd4:       tag_of = "R5";
      4'd11:      tag_of = "R7";
      default:    tag_of = (o > 4'd11) ? "R12" : "R6";
    endcase
  endfunction

  function automatic logic [39:0] sext(input logic [31:0] v);
    sext = {{8{v[31]}}, v};
  endfunction

  // Reference model of one slot, written from the requirements
  task automatic model(input logic iss, input logic [3:0] o, input logic [1:0] sx, input logic [1:0] sy,
                       input logic [2:0] dz, input logic udu, input logic [1:0] du,
                       input logic le, input logic [2:0] ls, input logic [31:0] ld);
    logic [39:0] a, b, s, r;
    logic [40:0] e;
    logic [2:0] dst;
    logic [2:0] dumap [4];
    logic wr, cu, zn;
    dumap[0] = 3'd0; dumap[1] = 3'd2; dumap[2] = 3'd6; dumap[3] = 3'd7;
    a = m[sx[1] ? (3'd6 + {2'b0, sx[0]}) : {2'b0, sx[0]}];
    b = m[3'd2 + {1'b0, sy}];
    s = (o == 4'd6 || o == 4'd8 || o == 4'd10) ? b : a;
    wr = iss; cu = 1'b0; zn = 1'b1; e = '0;
    case (o)
      4'd0: begin e = a + 41'(b); e = 41'(a) + 41'(b); cu = 1'b1; end
      4'd1: begin e = 41'(a) - 41'(b); cu = 1'b1; end
      4'd2: begin e = 41'(a) + 41'(b) + 41'(mc); cu = 1'b1; end
      4'd3: begin e = 41'(a) - 41'(b) - 41'(mc); cu = 1'b1; end
      4'd4: begin e = 41'(a) - 41'(b); cu = 1'b1; wr = 1'b0; end
      4'd5, 4'd6: e = 41'(s);
      4'd7, 4'd8: begin e = s[39] ? (41'd0 - 41'(s)) : 41'(s); cu = 1'b1; end
      4'd9, 4'd10: begin e = 41'd0 - 41'(s); cu = 1'b1; end
      4'd11: begin e = '0; zn = 1'b0; end
      default: begin wr = 1'b0; zn = 1'b0; end
    endcase
    r = e[39:0];
    dst = ((o == 4'd0 || o == 4'd1) && udu) ? dumap[du] : dz;
    if (iss) begin
      if (cu) mc = e[40];
      if (zn) begin mz = (r == 0); mn = r[39]; end
      if (o == 4'd11) begin mz = 1'b1; mn = 1'b0; end
    end
    if (wr) m[dst] = (dst >= 3'd6) ? r : sext(r[31:0]);
    if (le) m[ls] = sext(ld);
  endtask

  task automatic compare_all(input string tag, input logic le, input logic [2:0] ls);
    vectors++;
    if ({flag_c, flag_z, flag_n} !== {mc, mz, mn}) begin
      miscompares++;
      $display("FAIL %s flags czn actual=%b%b%b expected=%b%b%b", tag, flag_c, flag_z, flag_n, mc, mz, mn);
    end
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i);
      #0.2;
      if (rd_data !== m[i]) begin
        miscompares++;
        $display("FAIL %s reg%0d actual=%h expected=%h", (le && ls == 3'(i)) ? "R11" : tag, i, rd_data, m[i]);
      end
    end
  endtask

  task automatic slot(input logic iss, input logic [3:0] o, input logic [1:0] sx, input logic [1:0] sy,
                      input logic [2:0] dz, input logic udu, input logic [1:0] du,
                      input logic le, input logic [2:0] ls, input logic [31:0] ld, input string tg);
    @(negedge clk);
    issue = iss; op = o; sx_sel = sx; sy_sel = sy; dz_sel = dz; use_du = udu; du_sel = du;
    ld_en = le; ld_sel = ls; ld_data = ld;
    model(iss, o, sx, sy, dz, udu, du, le, ls, ld);
    @(posedge clk);
    #0.3;
    compare_all((tg == "") ? (iss ? tag_of(o) : "R12") : tg, le, ls);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) m[i] = '0;
    mc = 0; mz = 0; mn = 0;
    repeat (3) @(posedge clk);
    #0.3;
    compare_all("R1", 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3: loads, then add into A0 and alternate destination Y0
    slot(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 32'd7, "R11");
    slot(0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 32'hFFFF_FFFD, "R11");
    slot(1, 4'd0, 2'd0, 2'd0, 3'd6, 0, 0, 0, 0, 0, "R2");
    slot(1, 4'd1, 2'd0, 2'd0, 3'd6, 1, 2'd1, 0, 0, 0, "R3");
    // R10: load into X0 in the same slot as an add reading X0
    slot(1, 4'd0, 2'd0, 2'd0, 3'd7, 0, 0, 1, 3'd0, 32'd100, "R10");
    // R11: load and ALU both target A1
    slot(1, 4'd0, 2'd0, 2'd0, 3'd7, 0, 0, 1, 3'd7, 32'h8000_0000, "R11");
    // 40-bit carry: A0 = -1, then A0 + Y0(=1) carries out, then chain with add-with-carry
    slot(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 32'd1, "R11");
    slot(0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 32'd1, "R11");
    slot(1, 4'd9, 2'd1, 2'd0, 3'd6, 0, 0, 0, 0, 0, "R6");
    slot(1, 4'd0, 2'd2, 2'd0, 3'd6, 0, 0, 0, 0, 0, "R3");
    slot(1, 4'd2, 2'd0, 2'd0, 3'd7, 1, 2'd0, 0, 0, 0, "R4");
    slot(1, 4'd3, 2'd0, 2'd0, 3'd1, 0, 0, 0, 0, 0, "R4");
    // R9: narrow destination truncates a 40-bit result
    slot(1, 4'd9, 2'd0, 2'd0, 3'd7, 0, 0, 0, 0, 0, "R9");
    slot(1, 4'd5, 2'd3, 2'd0, 3'd4, 0, 0, 0, 0, 0, "R9");
    slot(1, 4'd8, 2'd0, 2'd1, 3'd5, 0, 0, 0, 0, 0, "R6");
    slot(1, 4'd4, 2'd3, 2'd0, 3'd0, 0, 0, 0, 0, 0, "R5");
    slot(1, 4'd11, 0, 0, 3'd6, 0, 0, 0, 0, 0, "R7");
    slot(1, 4'd8, 0, 0, 3'd0, 0, 0, 0, 0, 0, "R8");
    slot(1, 4'd13, 0, 0, 3'd3, 0, 0, 1, 3'd5, 32'h1234_5678, "R12");
    slot(0, 4'd0, 0, 0, 3'd3, 0, 0, 0, 0, 0, "R12");

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d;
      case ($urandom % 4)
        0: d = $urandom;
        1: d = 32'h8000_0000 ^ ($urandom % 4);
        2: d = $urandom % 8;
        default: d = 32'hFFFF_FFFF - ($urandom % 4);
      endcase
      slot(($urandom % 8) != 0, 4'($urandom % 16), 2'($urandom), 2'($urandom), 3'($urandom),
           1'($urandom), 2'($urandom), ($urandom % 3) == 0, 3'($urandom), d, "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule